// File: doc/BRIEF.md
# Memory Clock-Stop Gating Controller

This block sits between a DRAM command scheduler and the memory clock gate. It takes the access commands the scheduler wants to send. It forwards them one cycle later on a registered command output. It also works out the earliest point at which the memory clock pair may be halted. For each accepted command it loads a completion tracker with the number of clock pulses the command still needs:
- for a read, the read data-out;
- for a write, the write data plus write recovery;
- for the other commands, their own timing constraint.

Once the tracker reaches zero, no command is waiting and CKE is high, the clock-gate enable drops. The external gate then parks the true clock low and the complementary clock high.

When a command arrives while the clock is stopped, it is held with ready low. The clock enable rises again and a fixed number of NOP cycles, at least one, go out before the command is accepted. CKE going low while stopped also restarts the clock, because clock stop is only legal with CKE high. The block runs on the free-running controller clock. Each cycle with the enable high is one memory clock pulse. Timing values arrive as static input ports, counted in memory clock cycles.

Top module: `ckstop_ctrl`

## Requirements
- R1: While reset is asserted, `ck_en_o` is 1 and `mem_cmd_o` is NOP (code 0). After reset release with no command pending and CKE high, `ck_en_o` is 0 within SYNC_STAGES+3 cycles.
- R2: A READ (code 2) leaves `ck_en_o` high for exactly CL + BL/2 cycles after the cycle in which it appears on `mem_cmd_o`. In the cycle after that, `ck_en_o` is 0.
- R3: A WRITE (code 3) leaves `ck_en_o` high for exactly BL/2 + tWR cycles after its output cycle, then drops it.
- R4: The enable stays high after the output cycle for exactly tRCD cycles after ACTIVE (code 1), tRP after PRECHARGE (code 4), tRFC after AUTO REFRESH (code 5) and tMRD after MODE REGISTER SET (code 6).
- R5: When commands overlap, the enable stays high until the longest remaining requirement of any issued command has expired, not only that of the last one.
- R6: `ck_en_o` never falls while CKE is low. If CKE goes low while the clock is stopped, `ck_en_o` returns to 1 within two cycles and stays 1 for as long as CKE stays low.
- R7: While the clock is stopped, `cmd_ready_o` is 0. A command that arrives then is preceded by exactly WAKE_NOPS cycles with `ck_en_o` high and `mem_cmd_o` NOP before it appears on `mem_cmd_o`.
- R8: `mem_cmd_o` is NOP in every cycle where `ck_en_o` is 0, and in the first cycle after `ck_en_o` rises.
- R9: An accepted command appears on `mem_cmd_o` with its input code unchanged in the cycle after the accepting edge. A 1 on `ck_en_o` means the clock runs; a 0 means the gate parks the true clock low and the complementary clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock, one memory clock pulse per cycle when enabled |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_i | input | 1 | Current CKE level driven to the memory |
| cmd_valid_i | input | 1 | Command request valid |
| cmd_code_i | input | 3 | Command code (NOP 0, ACT 1, READ 2, WRITE 3, PRE 4, REF 5, MRS 6) |
| cmd_ready_o | output | 1 | Command accepted on a clock edge where valid and ready are high |
| t_cl_i | input | TW | CAS latency in cycles |
| t_bl_i | input | TW | Burst length in data beats |
| t_rcd_i | input | TW | Activate-to-access time in cycles |
| t_wr_i | input | TW | Write recovery in cycles |
| t_rp_i | input | TW | Precharge time in cycles |
| t_rfc_i | input | TW | Refresh cycle time in cycles |
| t_mrd_i | input | TW | Mode register set time in cycles |
| ck_en_o | output | 1 | Clock-gate enable: 1 run, 0 park clock pair low/high |
| mem_cmd_o | output | 3 | Registered command sent to the memory |

## Verification
The assertions take for granted four things about the inputs:
- `cmd_code_i` carries only the seven defined codes;
- a raised `cmd_valid_i` stays up with a stable code until it is accepted;
- CKE changes only between clock edges;
- the timing ports hold still while commands are in flight.

The bench keeps within these limits by driving every input on the falling edge and fixing the timing values for the whole run. It lowers valid only right after it sees the command on the output, and it changes the code only in the same way, for back-to-back pairs.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } mem_cmd_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } gate_state_e;

endpackage

// File: rtl/ckstop_cost.sv
module ckstop_cost
  import ckstop_pkg::*;
#(
  parameter int TW = 6,
  parameter int CW = TW + 2
) (
  input  logic [2:0]    code,
  input  logic [TW-1:0] t_cl,
  input  logic [TW-1:0] t_bl,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_wr,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rfc,
  input  logic [TW-1:0] t_mrd,
  output logic [CW-1:0] need
);

  logic [CW-1:0] half_burst;

  // data moves on both edges, so a burst of N beats takes N/2 pulses
  assign half_burst = CW'(t_bl >> 1);

  always_comb begin
    unique case (mem_cmd_e'(code))
      CMD_RD:  need = CW'(t_cl) + half_burst;
      CMD_WR:  need = half_burst + CW'(t_wr);
      CMD_ACT: need = CW'(t_rcd);
      CMD_PRE: need = CW'(t_rp);
      CMD_REF: need = CW'(t_rfc);
      CMD_MRS: need = CW'(t_mrd);
      default: need = '0;
    endcase
  end

endmodule

// File: rtl/ckstop_tracker.sv
module ckstop_tracker #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] need,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] cnt_dec;
  logic          cnt_en;

  assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
  assign cnt_en  = run;

  // keep the longest outstanding requirement
  always_comb begin
    cnt_n = cnt_dec;
    if (load && (need > cnt_dec)) cnt_n = need;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign done = (cnt_q == '0);

  // R5: the clock is never gated while a requirement is outstanding
  p_idle_when_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0));

endmodule

// File: rtl/ckstop_seq.sv
module ckstop_seq
  import ckstop_pkg::*;
#(
  parameter int WAKE_NOPS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cke,
  input  logic       done,
  output logic       cmd_ready,
  output logic       load,
  output logic       clk_en,
  output logic [2:0] mem_cmd
);

  localparam int NW = (WAKE_NOPS > 1) ? $clog2(WAKE_NOPS + 1) : 1;
  localparam logic [NW-1:0] NOP_LAST = NW'(WAKE_NOPS - 1);

  gate_state_e   state_q, state_n;
  logic          clk_en_q, clk_en_n;
  logic [2:0]    mem_cmd_q, mem_cmd_n;
  logic [NW-1:0] nop_q, nop_n;
  logic          nop_en;
  logic          accept;

  assign cmd_ready = (state_q == ST_RUN) ||
                     ((state_q == ST_WAKE) && (nop_q == '0));
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_n   = state_q;
    clk_en_n  = clk_en_q;
    mem_cmd_n = CMD_NOP;
    nop_n     = nop_q;
    nop_en    = 1'b0;
    if (accept) mem_cmd_n = cmd_code;
    unique case (state_q)
      ST_RUN: begin
        if (!cmd_valid && done && cke) begin
          state_n  = ST_STOP;
          clk_en_n = 1'b0;
        end
      end
      ST_STOP: begin
        if (cmd_valid || !cke) begin
          state_n  = ST_WAKE;
          clk_en_n = 1'b1;
          nop_n    = NOP_LAST;
          nop_en   = 1'b1;
        end
      end
      ST_WAKE: begin
        if (nop_q == '0) begin
          state_n = ST_RUN;
        end else begin
          nop_n  = nop_q - 1'b1;
          nop_en = 1'b1;
        end
      end
      default: begin
        state_n  = ST_RUN;
        clk_en_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      clk_en_q  <= 1'b1;
      mem_cmd_q <= CMD_NOP;
    end else begin
      state_q   <= state_n;
      clk_en_q  <= clk_en_n;
      mem_cmd_q <= mem_cmd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nop_q <= '0;
    else if (nop_en) nop_q <= nop_n;
  end

  assign load    = accept;
  assign clk_en  = clk_en_q;
  assign mem_cmd = mem_cmd_q;

  // R8: nothing but NOP reaches the memory while the clock is parked
  p_no_cmd_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_q |-> (mem_cmd_q == CMD_NOP));

  // R8: the first pulse after a restart carries NOP
  p_nop_after_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_q) |-> (mem_cmd_q == CMD_NOP));

  // R7: requests are stalled while stopped
  p_ready_low_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> !cmd_ready);

  // R5: stopping follows tracker completion with no request waiting
  p_stop_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_q) |-> $past(done && !cmd_valid));

endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl #(
  parameter int TW          = 6,
  parameter int WAKE_NOPS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_code_i,
  output logic          cmd_ready_o,
  input  logic [TW-1:0] t_cl_i,
  input  logic [TW-1:0] t_bl_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_wr_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rfc_i,
  input  logic [TW-1:0] t_mrd_i,
  output logic          ck_en_o,
  output logic [2:0]    mem_cmd_o
);

  localparam int CW = TW + 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  logic [CW-1:0]          need;
  logic                   load;
  logic                   done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  ckstop_cost #(.TW(TW), .CW(CW)) i_cost (
    .code  (cmd_code_i),
    .t_cl  (t_cl_i),
    .t_bl  (t_bl_i),
    .t_rcd (t_rcd_i),
    .t_wr  (t_wr_i),
    .t_rp  (t_rp_i),
    .t_rfc (t_rfc_i),
    .t_mrd (t_mrd_i),
    .need  (need)
  );

  ckstop_tracker #(.CW(CW)) i_tracker (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (ck_en_o),
    .load  (load),
    .need  (need),
    .done  (done)
  );

  ckstop_seq #(.WAKE_NOPS(WAKE_NOPS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid_i),
    .cmd_code  (cmd_code_i),
    .cke       (cke_i),
    .done      (done),
    .cmd_ready (cmd_ready_o),
    .load      (load),
    .clk_en    (ck_en_o),
    .mem_cmd   (mem_cmd_o)
  );

  // R6: clock stop never starts with CKE low
  p_cke_blocks_stop_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ck_en_o) |-> $past(cke_i));

endmodule

// File: tb/test_ckstop_ctrl.sv
module test_ckstop_ctrl;

  localparam int TW = 6;
  localparam int WAKE_NOPS = 2;
  localparam int SYNC_STAGES = 2;
  localparam int CL = 3, BL = 8, TRCD = 3, TWR = 2, TRP = 4, TRFC = 12, TMRD = 2;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, MRS = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic valid = 1'b0;
  logic [2:0] code = 3'd0;
  logic ready, ck_en;
  logic [2:0] mem_cmd;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ckstop_ctrl #(.TW(TW), .WAKE_NOPS(WAKE_NOPS), .SYNC_STAGES(SYNC_STAGES)) i_ckstop_ctrl (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cmd_valid_i(valid), .cmd_code_i(code),
    .cmd_ready_o(ready),
    .t_cl_i(TW'(CL)), .t_bl_i(TW'(BL)), .t_rcd_i(TW'(TRCD)), .t_wr_i(TW'(TWR)),
    .t_rp_i(TW'(TRP)), .t_rfc_i(TW'(TRFC)), .t_mrd_i(TW'(TMRD)),
    .ck_en_o(ck_en), .mem_cmd_o(mem_cmd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // wake from stop, issue c1 (and optionally c2 back to back), count pulses after last
  task automatic issue(input logic [2:0] c1, input bit two, input logic [2:0] c2,
                       input int exp_pulses, input string req);
    int wakes = 0;
    int pulses = 0;
    bit seen = 1'b0;
    chk(ck_en == 1'b0, "R7 stopped before issue", ck_en, 0);
    @(negedge clk);
    valid = 1'b1; code = c1;
    #1 chk(ready == 1'b0, "R7 ready low while stopped", ready, 0);
    for (int i = 0; i < 40; i++) begin
      tick();
      if (mem_cmd == c1) begin seen = 1'b1; break; end
      chk(mem_cmd == NOP, "R8 NOP before command", mem_cmd, NOP);
      if (ck_en) wakes++;
    end
    chk(seen, "R9 command reaches output", seen, 1);
    chk(wakes == WAKE_NOPS, "R7 restart NOP count", wakes, WAKE_NOPS);
    if (two) begin
      code = c2;
      tick();
      chk(mem_cmd == c2, "R9 second command follows", mem_cmd, c2);
    end
    valid = 1'b0;
    for (int i = 0; i < 80; i++) begin
      tick();
      if (!ck_en) break;
      pulses++;
    end
    chk(pulses == exp_pulses, req, pulses, exp_pulses);
    for (int i = 0; i < 3; i++) begin
      chk(mem_cmd == NOP && ck_en == 1'b0, "R8 gated output NOP", mem_cmd, NOP);
      tick();
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk(ck_en == 1'b1, "R1 enable in reset", ck_en, 1);
    chk(mem_cmd == NOP, "R1 NOP in reset", mem_cmd, NOP);
    @(negedge clk) rst_n = 1'b1;
    repeat (SYNC_STAGES + 3) tick();
    chk(ck_en == 1'b0, "R1 idle stop after reset", ck_en, 0);
  endtask

  task automatic t_singles();
    issue(RD,  1'b0, NOP, CL + BL / 2,  "R2 read pulses");
    issue(WR,  1'b0, NOP, BL / 2 + TWR, "R3 write pulses");
    issue(ACT, 1'b0, NOP, TRCD, "R4 activate pulses");
    issue(PRE, 1'b0, NOP, TRP,  "R4 precharge pulses");
    issue(REF, 1'b0, NOP, TRFC, "R4 refresh pulses");
    issue(MRS, 1'b0, NOP, TMRD, "R4 mode set pulses");
  endtask

  task automatic t_overlap();
    // long refresh still pending when the short precharge goes out
    issue(REF, 1'b1, PRE, (TRFC - 1 > TRP) ? TRFC - 1 : TRP, "R5 refresh then precharge");
    // later command longer than the remainder
    issue(PRE, 1'b1, RD, (TRP - 1 > CL + BL / 2) ? TRP - 1 : CL + BL / 2, "R5 precharge then read");
  endtask

  task automatic t_cke();
    bit held = 1'b1;
    @(negedge clk) cke = 1'b0;
    tick(); tick();
    chk(ck_en == 1'b1, "R6 restart on CKE low", ck_en, 1);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (!ck_en) held = 1'b0;
    end
    chk(held, "R6 running while CKE low", held, 1);
    @(negedge clk); valid = 1'b1; code = ACT;
    tick();
    chk(mem_cmd == ACT, "R9 accepted with CKE low", mem_cmd, ACT);
    valid = 1'b0;
    held = 1'b1;
    for (int i = 0; i < TRCD + 10; i++) begin
      tick();
      if (!ck_en) held = 1'b0;
    end
    chk(held, "R6 no stop after completion with CKE low", held, 1);
    @(negedge clk) cke = 1'b1;
    tick(); tick();
    chk(ck_en == 1'b0, "R6 stop once CKE high", ck_en, 0);
  endtask

  initial begin
    t_reset();
    t_singles();
    t_overlap();
    t_cke();
    issue(WR, 1'b0, NOP, BL / 2 + TWR, "R3 write after CKE test");
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule